// File: doc/BRIEF.md
# Masked Data Address Watchpoint Unit

This unit watches the data side of a processor pipeline for accesses that touch software-chosen memory regions. It holds two watchpoint channels. Each channel has an address register and a control register. The control register holds a low-order ignore mask, which widens the address into a power-of-two aligned region. It also holds separate enables for loads and for stores. Both registers are loaded through a single-cycle register write port.

Every cycle the unit compares the presented access against both channels: address, byte count and direction. If any byte of the access falls inside an armed region, the unit raises a hit in the same cycle, before the access commits. It also raises a suppress signal, which blocks the store write or the load retirement. Alongside the hit it presents the winning channel index and a debug cause word. Hits are taken only while the processor's current interrupt level is below its configured debug level.

Top module: `wpt_unit`

## Requirements
- R1: Control bit 31 arms a channel for stores and bit 30 arms it for loads. An access whose direction is not armed never matches, and a channel with both bits clear never matches.
- R2: Control bits 5:0 form an ignore mask. With a contiguous run of n ones starting at bit 0, the watched region is the 2^n-byte block that contains the address register, aligned to 2^n.
- R3: A 1-, 2- or 4-byte access at address a covers bytes a through a+size-1. It matches a channel when any of those bytes lies in that channel's region, including partial overlap at either edge.
- R4: Only the unbroken run of ones from bit 0 upward counts toward the mask. Mask bits above the first zero are ignored.
- R5: hit_o and suppress_o are combinational in the presented access and never rise without acc_valid_i. suppress_o equals hit_o.
- R6: When a hit is reported, cause_o has bit 2 set and carries the reporting channel number in bits 11:8, with every other bit zero. Without a hit, cause_o is zero.
- R7: A hit is reported only when cur_level_i is strictly less than dbg_level_i, compared as unsigned values.
- R8: When both channels match, channel 0 is reported. A match on channel 1 alone reports channel 1.
- R9: A write to a channel register affects matching only from the cycle after the write's clock edge.
- R10: Reset clears both control registers and both address registers, so no access hits until a channel is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_chan_i | input | 1 | Channel selected for the write |
| cfg_is_ctrl_i | input | 1 | 1 writes the control register, 0 writes the address register |
| cfg_wdata_i | input | 32 | Write data |
| acc_valid_i | input | 1 | A data access is presented this cycle |
| acc_addr_i | input | 32 | Byte address of the access |
| acc_size_i | input | 3 | Access size in bytes: 1, 2 or 4 |
| acc_store_i | input | 1 | 1 for a store, 0 for a load |
| cur_level_i | input | 4 | Current interrupt level |
| dbg_level_i | input | 4 | Configured debug level |
| hit_o | output | 1 | Watchpoint hit on the presented access |
| hit_chan_o | output | 1 | Index of the reporting channel |
| suppress_o | output | 1 | Block the access from taking effect |
| cause_o | output | 12 | Debug cause: bit 2 is the hit flag, bits 11:8 hold the channel |

## Verification
The checks assume that acc_size_i is always 1, 2 or 4 and that an access never wraps past the top of the address space. No other size and no wrapping access is defined. The sweeps therefore use only those three sizes, on addresses far from the top of memory. The reset check counts on the control register returning to zero. The checker only tracks whether any control write has set an enable bit since reset, because its reset-disarm property depends on that alone.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int DATA_W         = 32;
  localparam int CTRL_ST_BIT    = 31;
  localparam int CTRL_LD_BIT    = 30;
  localparam int MASK_W         = 6;
  localparam int CAUSE_W        = 12;
  localparam int CAUSE_HIT_BIT  = 2;
  localparam int CAUSE_CHAN_LSB = 8;
  localparam int CAUSE_CHAN_W   = 4;

  typedef struct packed {
    logic              st_en;
    logic              ld_en;
    logic [MASK_W-1:0] mask;
  } wpt_ctrl_t;
endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs
  import wpt_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  parameter int ADDR_W   = 32,
  parameter int CHAN_W   = 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CHAN_W-1:0]                chan_i,
  input  logic                             is_ctrl_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_CHAN-1:0][ADDR_W-1:0]  addr_o,
  output wpt_ctrl_t [NUM_CHAN-1:0]         ctrl_o
);
  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    logic sel;
    assign sel = we_i && (chan_i == CHAN_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o[i] <= '0;
        ctrl_o[i] <= '0;
      end else if (sel) begin
        if (is_ctrl_i) begin
          ctrl_o[i].st_en <= wdata_i[CTRL_ST_BIT];
          ctrl_o[i].ld_en <= wdata_i[CTRL_LD_BIT];
          ctrl_o[i].mask  <= wdata_i[MASK_W-1:0];
        end else begin
          addr_o[i] <= wdata_i[ADDR_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/wpt_chan_match.sv
module wpt_chan_match
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  wpt_ctrl_t         ctrl_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [2:0]        acc_size_i,
  input  logic              acc_store_i,
  output logic              match_o
);
  localparam int EXT_W = ADDR_W + 1;

  // Keep only the unbroken run of ones from bit 0.
  logic [MASK_W-1:0] eff_mask;
  assign eff_mask[0] = ctrl_i.mask[0];
  for (genvar k = 1; k < MASK_W; k++) begin : g_run
    assign eff_mask[k] = eff_mask[k-1] & ctrl_i.mask[k];
  end

  logic [ADDR_W-1:0] region_mask, region_lo, region_hi;
  logic [EXT_W-1:0]  acc_lo, acc_hi;
  logic              dir_ok, overlap;

  assign region_mask = {{(ADDR_W-MASK_W){1'b0}}, eff_mask};
  assign region_lo   = base_i & ~region_mask;
  assign region_hi   = region_lo | region_mask;

  assign acc_lo = {1'b0, acc_addr_i};
  assign acc_hi = acc_lo + {{(EXT_W-3){1'b0}}, acc_size_i} - EXT_W'(1);

  assign dir_ok  = acc_store_i ? ctrl_i.st_en : ctrl_i.ld_en;
  assign overlap = (acc_lo <= {1'b0, region_hi}) && (acc_hi >= {1'b0, region_lo});
  assign match_o = acc_valid_i && dir_ok && overlap;
endmodule

// File: rtl/wpt_hit_arb.sv
module wpt_hit_arb
  import wpt_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  parameter int CHAN_W   = 1,
  parameter int LEVEL_W  = 4
) (
  input  logic [NUM_CHAN-1:0] match_i,
  input  logic [LEVEL_W-1:0]  cur_level_i,
  input  logic [LEVEL_W-1:0]  dbg_level_i,
  output logic                hit_o,
  output logic [CHAN_W-1:0]   chan_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  logic [CHAN_W-1:0] sel;
  logic              level_ok;

  // Lowest index wins: scan downward so the last assignment is the smallest.
  always_comb begin
    sel = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (match_i[i]) sel = CHAN_W'(i);
    end
  end

  assign level_ok = cur_level_i < dbg_level_i;
  assign hit_o    = (|match_i) && level_ok;
  assign chan_o   = hit_o ? sel : '0;

  always_comb begin
    cause_o = '0;
    if (hit_o) begin
      cause_o[CAUSE_HIT_BIT] = 1'b1;
      cause_o[CAUSE_CHAN_LSB +: CAUSE_CHAN_W] = CAUSE_CHAN_W'(sel);
    end
  end
endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  parameter int ADDR_W   = 32,
  parameter int LEVEL_W  = 4,
  localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CHAN_W-1:0]   cfg_chan_i,
  input  logic                cfg_is_ctrl_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  input  logic                acc_valid_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [2:0]          acc_size_i,
  input  logic                acc_store_i,
  input  logic [LEVEL_W-1:0]  cur_level_i,
  input  logic [LEVEL_W-1:0]  dbg_level_i,
  output logic                hit_o,
  output logic [CHAN_W-1:0]   hit_chan_o,
  output logic                suppress_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  logic [NUM_CHAN-1:0][ADDR_W-1:0] wp_addr;
  wpt_ctrl_t [NUM_CHAN-1:0]        wp_ctrl;
  logic [NUM_CHAN-1:0]             wp_match;

  wpt_cfg_regs #(
    .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W)
  ) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .chan_i   (cfg_chan_i),
    .is_ctrl_i(cfg_is_ctrl_i),
    .wdata_i  (cfg_wdata_i),
    .addr_o   (wp_addr),
    .ctrl_o   (wp_ctrl)
  );

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_match
    wpt_chan_match #(.ADDR_W(ADDR_W)) match_i (
      .ctrl_i     (wp_ctrl[i]),
      .base_i     (wp_addr[i]),
      .acc_valid_i(acc_valid_i),
      .acc_addr_i (acc_addr_i),
      .acc_size_i (acc_size_i),
      .acc_store_i(acc_store_i),
      .match_o    (wp_match[i])
    );
  end

  wpt_hit_arb #(
    .NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W), .LEVEL_W(LEVEL_W)
  ) arb_i (
    .match_i    (wp_match),
    .cur_level_i(cur_level_i),
    .dbg_level_i(dbg_level_i),
    .hit_o      (hit_o),
    .chan_o     (hit_chan_o),
    .cause_o    (cause_o)
  );

  assign suppress_o = hit_o;
endmodule

// File: rtl/wpt_unit_chk.sv
module wpt_unit_chk
  import wpt_pkg::*;
#(
  parameter int LEVEL_W = 4,
  parameter int CHAN_W  = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic               cfg_is_ctrl_i,
  input logic [1:0]         cfg_en_bits_i,
  input logic               acc_valid_i,
  input logic [LEVEL_W-1:0] cur_level_i,
  input logic [LEVEL_W-1:0] dbg_level_i,
  input logic               hit_o,
  input logic [CHAN_W-1:0]  hit_chan_o,
  input logic               suppress_o,
  input logic [CAUSE_W-1:0] cause_o
);
  logic armed_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_seen <= 1'b0;
    else if (cfg_we_i && cfg_is_ctrl_i && (|cfg_en_bits_i)) armed_seen <= 1'b1;
  end

  a_r5_no_hit_without_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!hit_o && !suppress_o));

  a_r5_suppress_follows_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> suppress_o);

  a_r7_level_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (cur_level_i < dbg_level_i));

  a_r6_cause_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (cause_o[CAUSE_HIT_BIT] &&
               cause_o[CAUSE_CHAN_LSB +: CAUSE_CHAN_W] == CAUSE_CHAN_W'(hit_chan_o)));

  a_r6_cause_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (cause_o == '0));

  a_r10_disarmed_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_seen |-> !hit_o);
endmodule

bind wpt_unit wpt_unit_chk #(.LEVEL_W(LEVEL_W), .CHAN_W(CHAN_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_is_ctrl_i(cfg_is_ctrl_i),
  .cfg_en_bits_i(cfg_wdata_i[31:30]),
  .acc_valid_i  (acc_valid_i),
  .cur_level_i  (cur_level_i),
  .dbg_level_i  (dbg_level_i),
  .hit_o        (hit_o),
  .hit_chan_o   (hit_chan_o),
  .suppress_o   (suppress_o),
  .cause_o      (cause_o)
);

// File: tb/wpt_unit_tb_top.sv
module wpt_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [0:0]  cfg_chan_i = '0;
  logic        cfg_is_ctrl_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [2:0]  acc_size_i = 3'd1;
  logic        acc_store_i = 1'b0;
  logic [3:0]  cur_level_i = 4'd0;
  logic [3:0]  dbg_level_i = 4'd15;
  logic        hit_o;
  logic [0:0]  hit_chan_o;
  logic        suppress_o;
  logic [11:0] cause_o;

  wpt_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_chan_i(cfg_chan_i), .cfg_is_ctrl_i(cfg_is_ctrl_i),
    .cfg_wdata_i(cfg_wdata_i),
    .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i), .acc_size_i(acc_size_i),
    .acc_store_i(acc_store_i), .cur_level_i(cur_level_i), .dbg_level_i(dbg_level_i),
    .hit_o(hit_o), .hit_chan_o(hit_chan_o), .suppress_o(suppress_o), .cause_o(cause_o)
  );

  always #5 clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] sh_addr [2];
  logic        sh_st   [2];
  logic        sh_ld   [2];
  logic [5:0]  sh_mask [2];

  task automatic check(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (addr 0x%08h size %0d st %0b)",
               tag, what, act, exp, acc_addr_i, acc_size_i, acc_store_i);
    end
  endtask

  function automatic bit ch_match(int c, logic [31:0] a, int sz, bit st);
    int run = 0;
    longint len, base, lo, hi;
    bit en;
    for (int k = 0; k < 6; k++) if (run == k && sh_mask[c][k]) run++;
    len  = longint'(1) << run;
    base = longint'(sh_addr[c]) & ~(len - 1);
    lo   = longint'(a);
    hi   = lo + sz - 1;
    en   = st ? sh_st[c] : sh_ld[c];
    return en && (lo <= base + len - 1) && (hi >= base);
  endfunction

  task automatic cfg_write(int ch, bit is_ctrl, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_chan_i = 1'(ch); cfg_is_ctrl_i = is_ctrl; cfg_wdata_i = d;
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
    if (is_ctrl) begin
      sh_st[ch] = d[31]; sh_ld[ch] = d[30]; sh_mask[ch] = d[5:0];
    end else sh_addr[ch] = d;
  endtask

  task automatic compare(string tag);
    bit m0, m1, exp_hit;
    int exp_chan;
    m0 = acc_valid_i && ch_match(0, acc_addr_i, int'(acc_size_i), acc_store_i);
    m1 = acc_valid_i && ch_match(1, acc_addr_i, int'(acc_size_i), acc_store_i);
    exp_hit  = (m0 || m1) && (cur_level_i < dbg_level_i);
    exp_chan = (exp_hit && !m0) ? 1 : 0;
    check(tag, "hit", longint'(hit_o), longint'(exp_hit));
    check("R5", "suppress", longint'(suppress_o), longint'(exp_hit));
    check("R6", "cause", longint'(cause_o), exp_hit ? longint'(4 | (exp_chan << 8)) : 0);
    if (exp_hit) check("R8", "chan", longint'(hit_chan_o), longint'(exp_chan));
  endtask

  task automatic probe(string tag, logic [31:0] a, int sz, bit st);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_size_i = 3'(sz); acc_store_i = st;
    #1 compare(tag);
  endtask

  initial begin
    #1_500_000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int sizes [3] = '{1, 2, 4};
    logic [5:0] masks [8] = '{6'h00, 6'h01, 6'h03, 6'h07, 6'h3f, 6'h3e, 6'h05, 6'h1d};
    for (int c = 0; c < 2; c++) begin
      sh_addr[c] = '0; sh_st[c] = 0; sh_ld[c] = 0; sh_mask[c] = '0;
    end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R10: nothing armed after reset
    foreach (sizes[s]) begin
      probe("R10", 32'h0, sizes[s], 1'b0);
      probe("R10", 32'h0, sizes[s], 1'b1);
    end

    // R1: direction enables
    cfg_write(0, 1'b0, 32'h1000_0040);
    for (int e = 0; e < 4; e++) begin
      cfg_write(0, 1'b1, {e[1], e[0], 30'h0});
      probe("R1", 32'h1000_0040, 1, 1'b0);
      probe("R1", 32'h1000_0040, 4, 1'b1);
    end

    // R2/R3/R4: mask and overlap sweep
    cfg_write(0, 1'b0, 32'hD000_007D);
    foreach (masks[m]) begin
      cfg_write(0, 1'b1, {2'b11, 24'h0, masks[m]});
      for (int off = 'h40; off < 'hC0; off++) begin
        foreach (sizes[s]) begin
          string tag;
          tag = (m >= 5) ? "R4" : ((sizes[s] > 1) ? "R3" : "R2");
          probe(tag, 32'hD000_0000 + 32'(off), sizes[s], off[0]);
        end
      end
    end

    // R8: both channels overlap; channel 0 has priority
    cfg_write(0, 1'b0, 32'hD000_007C);
    cfg_write(0, 1'b1, 32'hC000_0001);
    cfg_write(1, 1'b0, 32'hD000_0078);
    cfg_write(1, 1'b1, 32'hC000_0007);
    for (int off = 'h70; off < 'h88; off++)
      foreach (sizes[s]) probe("R8", 32'hD000_0000 + 32'(off), sizes[s], off[1]);

    // R7: level gating
    for (int cl = 0; cl < 16; cl++)
      for (int dl = 0; dl < 16; dl++) begin
        @(negedge clk_i);
        cur_level_i = 4'(cl); dbg_level_i = 4'(dl);
        acc_valid_i = 1'b1; acc_addr_i = 32'hD000_007C; acc_size_i = 3'd1; acc_store_i = 1'b0;
        #1 compare("R7");
      end
    cur_level_i = 4'd0; dbg_level_i = 4'd15;

    // R5: no access, no hit
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_addr_i = 32'hD000_007C;
    #1 compare("R5");

    // R9: write takes effect after the clock edge
    cfg_write(1, 1'b1, 32'h0);
    cfg_write(0, 1'b1, 32'h0);
    cfg_write(0, 1'b0, 32'h2000_0010);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_addr_i = 32'h2000_0010; acc_size_i = 3'd2; acc_store_i = 1'b1;
    cfg_we_i = 1'b1; cfg_chan_i = 1'b0; cfg_is_ctrl_i = 1'b1; cfg_wdata_i = 32'h8000_0000;
    #1 check("R9", "hit before edge", longint'(hit_o), 0);
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
    sh_st[0] = 1'b1; sh_ld[0] = 1'b0; sh_mask[0] = '0;
    check("R9", "hit after edge", longint'(hit_o), 1);
    compare("R9");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule